// File: doc/BRIEF.md
# Multi-Partition Flash Command Decoder

This block is the command front end of a NOR-style flash split into several partitions. Software issues write bus cycles, each carrying an address and a 16-bit data word. The decoder interprets the low byte of the data as an opcode and runs one-cycle commands directly. For two-cycle commands (block erase, protection-word program, lock program, configuration set) it holds the setup cycle until the confirm cycle arrives. Each partition keeps its own read mode: array, status or register. A read returns, one cycle later, whatever the addressed partition's mode selects.

A pending setup moves only the partition it addressed into status mode. Reads of that partition show status until the confirm arrives, and these reads do not cancel the sequence. Reads of other partitions in array mode still return stored words. The storage is a small word array that resets to a known pattern. Erase is modelled as a busy period of fixed length that ends with the block filled with FFFFh.

Top module: `flash_cmd_ui`

## Requirements
- R1: After reset every partition is in array mode and `rdValid`/`rdData` are 0. The word at array index k, formed as {addr[15:14], addr[5:0]}, reads {A5h, k[7:0]}. Status reads as 0080h.
- R2: A write whose low data byte is FFh, with no sequence pending, puts the addressed partition (addr[15:14]) in array mode.
- R3: A setup write of 20h, 60h or C0h puts the addressed partition in status mode. Reads of it return status, and reads of other array-mode partitions return array data.
- R4: Reads issued between the setup and the confirm cycle do not cancel the pending sequence.
- R5: Erase is 20h followed by D0h, with the second address in the same partition and the same 16-word block (addr[5:4]). The status word then shows bit 7 = 0 for exactly ERASE_CYCLES clocks. After that every word of the block reads FFFFh and other blocks are unchanged.
- R6: A confirm with the wrong code or the wrong address sets status bit 5 and performs no operation. The setup partition stays in status mode.
- R7: Configuration set is 60h followed by 03h. The new value is the confirm cycle's address, taken at any partition. In register mode, addresses other than 0080h to 0084h read the configuration value.
- R8: Protection program is C0h and then the data word, both written to the same address in 0081h to 0084h. In register mode that address returns the data. A mismatched address is a sequence error.
- R9: Lock program is C0h and then FFFDh, both at 0080h, and it ANDs FFFDh into the lock word (reset FFFFh, read at 0080h in register mode). Once lock bit 1 is 0, a protection program sets status bit 4 and leaves the word unchanged.
- R10: A first-cycle opcode outside {FFh, 70h, 90h, 50h, 20h, C0h, 60h} has no effect on any mode. The same holds for C0h outside 0080h to 0084h.
- R11: Opcode 50h clears status bits 5 and 4 and leaves the mode unchanged. Opcode 70h selects status mode and 90h selects register mode.
- R12: While erase is busy every write is ignored.
- R13: `rdValid` is 1 exactly one cycle after a cycle with `rdEn`=1 and `wrEn`=0, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write bus cycle |
| rdEn | input | 1 | Read bus cycle (ignored when wrEn is 1) |
| addr | input | ADDR_W | Word address; top bits select the partition |
| wrData | input | 16 | Write data / opcode in low byte |
| rdData | output | 16 | Registered read result |
| rdValid | output | 1 | rdData updated this cycle |

## Verification
The assertions watch, on every clock, the per-partition modes that setup and read-array writes select, and the one-cycle read latency. They also check that busy begins after an erase start and lasts exactly ERASE_CYCLES clocks, and that no command strobe or mode change occurs while busy. Other behaviour can only be shown by the bench's scenarios: the data that comes back through each read mode, erased block contents against untouched neighbours, sticky error bits after bad confirms, the lock preventing a protection write, and the configuration value taken from the address bus.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;
  localparam int DATA_W = 16;

  localparam logic [7:0] OP_READ_ARRAY    = 8'hFF;
  localparam logic [7:0] OP_READ_STATUS   = 8'h70;
  localparam logic [7:0] OP_READ_REG      = 8'h90;
  localparam logic [7:0] OP_CLR_STATUS    = 8'h50;
  localparam logic [7:0] OP_ERASE_SETUP   = 8'h20;
  localparam logic [7:0] OP_ERASE_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_PROT_SETUP    = 8'hC0;
  localparam logic [7:0] OP_CFG_SETUP     = 8'h60;
  localparam logic [7:0] OP_CFG_CONFIRM   = 8'h03;
  localparam logic [DATA_W-1:0] LOCK_CONFIRM = 16'hFFFD;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_REG    = 2'd2
  } readMode_t;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_ERASE = 2'd1,
    PEND_PROT  = 2'd2,
    PEND_CFG   = 2'd3
  } pendKind_t;

  // Strobes from control to datapath; the datapath takes address and data
  // from the bus in the same cycle.
  typedef struct packed {
    logic eraseStart;
    logic protWr;
    logic lockWr;
    logic cfgWr;
    logic seqErr;
    logic clrStatus;
  } cuiStrobe_t;
endpackage

// File: rtl/flash_cui_ctrl.sv
module flash_cui_ctrl
  import flash_cui_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_PART   = 4,
  parameter int LOCAL_W    = 6,
  parameter int BLK_W      = 4,
  parameter int PROT_WORDS = 4,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 16'h0080,
  parameter logic [ADDR_W-1:0] PROT_BASE = 16'h0081
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wrData,
  input  logic                         busy,
  output readMode_t [NUM_PART-1:0]     partModes,
  output logic                         seqPending,
  output cuiStrobe_t                   strb
);
  localparam int PART_W = $clog2(NUM_PART);

  readMode_t [NUM_PART-1:0] modeD;
  pendKind_t                kindQ, kindD;
  logic [ADDR_W-1:0]        pendAddrQ, pendAddrD;
  logic [PART_W-1:0]        addrPart;
  logic [7:0]               op;
  logic                     sameBlock, protHit, lockHit;

  assign addrPart   = addr[ADDR_W-1 -: PART_W];
  assign op         = wrData[7:0];
  assign seqPending = (kindQ != PEND_NONE);
  assign sameBlock  = (addrPart == pendAddrQ[ADDR_W-1 -: PART_W]) &&
                      (addr[LOCAL_W-1:BLK_W] == pendAddrQ[LOCAL_W-1:BLK_W]);
  assign lockHit    = (addr == LOCK_ADDR);
  assign protHit    = (addr >= PROT_BASE) && (addr < PROT_BASE + ADDR_W'(PROT_WORDS));

  always_comb begin
    modeD     = partModes;
    kindD     = kindQ;
    pendAddrD = pendAddrQ;
    strb      = '0;
    if (wrEn && !busy) begin
      if (kindQ != PEND_NONE) begin
        kindD = PEND_NONE;
        case (kindQ)
          PEND_ERASE: begin
            if (op == OP_ERASE_CONFIRM && sameBlock) strb.eraseStart = 1'b1;
            else                                     strb.seqErr     = 1'b1;
          end
          PEND_PROT: begin
            if (addr != pendAddrQ)                   strb.seqErr = 1'b1;
            else if (pendAddrQ == LOCK_ADDR) begin
              if (wrData == LOCK_CONFIRM)            strb.lockWr = 1'b1;
              else                                   strb.seqErr = 1'b1;
            end else                                 strb.protWr = 1'b1;
          end
          PEND_CFG: begin
            if (op == OP_CFG_CONFIRM)                strb.cfgWr  = 1'b1;
            else                                     strb.seqErr = 1'b1;
          end
          default: ;
        endcase
      end else begin
        case (op)
          OP_READ_ARRAY:  modeD[addrPart] = MODE_ARRAY;
          OP_READ_STATUS: modeD[addrPart] = MODE_STATUS;
          OP_READ_REG:    modeD[addrPart] = MODE_REG;
          OP_CLR_STATUS:  strb.clrStatus  = 1'b1;
          OP_ERASE_SETUP: begin
            modeD[addrPart] = MODE_STATUS;
            kindD           = PEND_ERASE;
            pendAddrD       = addr;
          end
          OP_PROT_SETUP: begin
            if (protHit || lockHit) begin
              modeD[addrPart] = MODE_STATUS;
              kindD           = PEND_PROT;
              pendAddrD       = addr;
            end
          end
          OP_CFG_SETUP: begin
            modeD[addrPart] = MODE_STATUS;
            kindD           = PEND_CFG;
            pendAddrD       = addr;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      partModes <= {NUM_PART{MODE_ARRAY}};
      kindQ     <= PEND_NONE;
      pendAddrQ <= '0;
    end else begin
      partModes <= modeD;
      kindQ     <= kindD;
      pendAddrQ <= pendAddrD;
    end
  end
endmodule

// File: rtl/flash_cui_dp.sv
module flash_cui_dp
  import flash_cui_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int NUM_PART     = 4,
  parameter int LOCAL_W      = 6,
  parameter int BLK_W        = 4,
  parameter int PROT_WORDS   = 4,
  parameter int ERASE_CYCLES = 16,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 16'h0080,
  parameter logic [ADDR_W-1:0] PROT_BASE = 16'h0081
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  input  cuiStrobe_t               strb,
  input  readMode_t [NUM_PART-1:0] partModes,
  output logic                     busy,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdValid
);
  localparam int PART_W    = $clog2(NUM_PART);
  localparam int WORD_W    = PART_W + LOCAL_W;
  localparam int NUM_WORDS = 1 << WORD_W;
  localparam int BLK_WORDS = 1 << BLK_W;
  localparam int EBLK_W    = WORD_W - BLK_W;
  localparam int CNT_W     = $clog2(ERASE_CYCLES + 1);
  localparam int PIDX_W    = (PROT_WORDS > 1) ? $clog2(PROT_WORDS) : 1;

  logic [DATA_W-1:0] mem     [NUM_WORDS];
  logic [DATA_W-1:0] protReg [PROT_WORDS];
  logic [DATA_W-1:0] lockReg, cfgReg, statusWord, rdMux;
  logic              seqErrQ, progErrQ;
  logic [CNT_W-1:0]  busyCnt;
  logic [EBLK_W-1:0] eraseBlk;
  logic [WORD_W-1:0] wordIdx;
  logic [PIDX_W-1:0] protIdx;
  logic              protHit, protLocked, fillNow;
  readMode_t         curMode;

  assign wordIdx    = {addr[ADDR_W-1 -: PART_W], addr[LOCAL_W-1:0]};
  assign busy       = (busyCnt != '0);
  assign fillNow    = (busyCnt == CNT_W'(1));
  assign protLocked = !lockReg[1];
  assign protHit    = (addr >= PROT_BASE) && (addr < PROT_BASE + ADDR_W'(PROT_WORDS));
  assign protIdx    = PIDX_W'(addr - PROT_BASE);
  assign statusWord = {8'h00, !busy, 1'b0, seqErrQ, progErrQ, 4'h0};
  assign curMode    = partModes[addr[ADDR_W-1 -: PART_W]];

  always_comb begin
    case (curMode)
      MODE_STATUS: rdMux = statusWord;
      MODE_REG: begin
        if (addr == LOCK_ADDR) rdMux = lockReg;
        else if (protHit)      rdMux = protReg[protIdx];
        else                   rdMux = cfgReg;
      end
      default:     rdMux = mem[wordIdx];
    endcase
  end

  // Word store: known pattern at reset, block fill on the last busy cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= {8'hA5, 8'(i)};
    end else if (fillNow) begin
      for (int j = 0; j < BLK_WORDS; j++) mem[{eraseBlk, BLK_W'(j)}] <= '1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < PROT_WORDS; p++) protReg[p] <= '1;
      lockReg  <= '1;
      cfgReg   <= '0;
      seqErrQ  <= 1'b0;
      progErrQ <= 1'b0;
      busyCnt  <= '0;
      eraseBlk <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (strb.eraseStart) begin
        busyCnt  <= CNT_W'(ERASE_CYCLES);
        eraseBlk <= wordIdx[WORD_W-1:BLK_W];
      end else if (busy) begin
        busyCnt <= busyCnt - CNT_W'(1);
      end
      if (strb.protWr && !protLocked) protReg[protIdx] <= wrData;
      if (strb.lockWr)                lockReg <= lockReg & wrData;
      if (strb.cfgWr)                 cfgReg  <= DATA_W'(addr);
      if (strb.clrStatus) begin
        seqErrQ  <= 1'b0;
        progErrQ <= 1'b0;
      end else begin
        if (strb.seqErr)                  seqErrQ  <= 1'b1;
        if (strb.protWr && protLocked)    progErrQ <= 1'b1;
      end
      rdValid <= rdEn && !wrEn;
      if (rdEn && !wrEn) rdData <= rdMux;
    end
  end
endmodule

// File: rtl/flash_cmd_ui.sv
module flash_cmd_ui
  import flash_cui_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int NUM_PART     = 4,
  parameter int LOCAL_W      = 6,
  parameter int BLK_W        = 4,
  parameter int PROT_WORDS   = 4,
  parameter int ERASE_CYCLES = 16,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 16'h0080,
  parameter logic [ADDR_W-1:0] PROT_BASE = 16'h0081
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  output logic              rdValid
);
  readMode_t [NUM_PART-1:0] partModes;
  cuiStrobe_t               strb;
  logic                     busy;
  logic                     seqPending;

  flash_cui_ctrl #(
    .ADDR_W(ADDR_W), .NUM_PART(NUM_PART), .LOCAL_W(LOCAL_W), .BLK_W(BLK_W),
    .PROT_WORDS(PROT_WORDS), .LOCK_ADDR(LOCK_ADDR), .PROT_BASE(PROT_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .busy(busy), .partModes(partModes), .seqPending(seqPending), .strb(strb)
  );

  flash_cui_dp #(
    .ADDR_W(ADDR_W), .NUM_PART(NUM_PART), .LOCAL_W(LOCAL_W), .BLK_W(BLK_W),
    .PROT_WORDS(PROT_WORDS), .ERASE_CYCLES(ERASE_CYCLES),
    .LOCK_ADDR(LOCK_ADDR), .PROT_BASE(PROT_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .strb(strb), .partModes(partModes), .busy(busy),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/flash_cui_chk.sv
module flash_cui_chk
  import flash_cui_pkg::*;
#(
  parameter int NUM_PART     = 4,
  parameter int ERASE_CYCLES = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic                     rdEn,
  input logic [$clog2(NUM_PART)-1:0] wrPart,
  input logic [7:0]               wrOp,
  input logic                     rdValid,
  input logic                     busy,
  input logic                     seqPending,
  input cuiStrobe_t               strb,
  input readMode_t [NUM_PART-1:0] partModes
);
  localparam int RUN_W = $clog2(ERASE_CYCLES + 2);
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + RUN_W'(1);
    else           runLen <= '0;
  end

  a_r13_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn) |=> rdValid);
  a_r13_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && !wrEn) |=> !rdValid);
  a_r5_busy_follows_erase: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseStart |=> busy);
  a_r5_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runLen < RUN_W'(ERASE_CYCLES)));
  a_r5_busy_full_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == RUN_W'(ERASE_CYCLES)));
  a_r12_busy_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (strb == '0));
  a_r12_busy_modes_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> $stable(partModes));
  a_r3_setup_status: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy && !seqPending && (wrOp == OP_ERASE_SETUP || wrOp == OP_CFG_SETUP))
      |=> (partModes[$past(wrPart)] == MODE_STATUS));
  a_r2_read_array: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy && !seqPending && wrOp == OP_READ_ARRAY)
      |=> (partModes[$past(wrPart)] == MODE_ARRAY));
  a_r6_error_ends_sequence: assert property (@(posedge clk) disable iff (!rstN)
    strb.seqErr |=> !seqPending);
endmodule

bind flash_cmd_ui flash_cui_chk #(
  .NUM_PART(NUM_PART), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
  .wrPart(addr[ADDR_W-1 -: $clog2(NUM_PART)]), .wrOp(wrData[7:0]),
  .rdValid(rdValid), .busy(busy), .seqPending(seqPending),
  .strb(strb), .partModes(partModes)
);

// File: tb/flash_cmd_ui_tb.sv
`timescale 1ns/1ps
module flash_cmd_ui_tb;
  localparam int ERASE_CYCLES = 16;
  localparam int NVEC = 40;

  typedef struct packed {
    logic        isWr;
    logic [15:0] addr;
    logic [15:0] data;   // write data, or expected read data
    logic [7:0]  req;
  } vec_t;

  // Walked in order; each read entry is a check of the requirement given.
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'h0005, 16'hA505, 8'd1},   // R1 array pattern
    '{1'b0, 16'h4003, 16'hA543, 8'd1},   // R1 pattern, partition 1
    '{1'b1, 16'h8000, 16'h0070, 8'd11},
    '{1'b0, 16'h8000, 16'h0080, 8'd1},   // R1 status ready, no errors
    '{1'b1, 16'h8000, 16'h00FF, 8'd2},
    '{1'b0, 16'h8001, 16'hA581, 8'd2},   // R2 back to array
    '{1'b1, 16'h4010, 16'h0020, 8'd3},
    '{1'b0, 16'h4011, 16'h0080, 8'd3},   // R3 setup partition reads status
    '{1'b0, 16'h0002, 16'hA502, 8'd3},   // R3 other partition array
    '{1'b1, 16'h4020, 16'h00D0, 8'd6},   // R6 confirm in wrong block
    '{1'b0, 16'h4000, 16'h00A0, 8'd6},   // R6 bit 5 set, still status
    '{1'b1, 16'h4000, 16'h0050, 8'd11},
    '{1'b0, 16'h4000, 16'h0080, 8'd11},  // R11 errors cleared, mode kept
    '{1'b1, 16'h4000, 16'h0012, 8'd10},
    '{1'b0, 16'h4000, 16'h0080, 8'd10},  // R10 stays status
    '{1'b1, 16'h4000, 16'h00FF, 8'd2},
    '{1'b1, 16'h4000, 16'h0077, 8'd10},
    '{1'b0, 16'h4000, 16'hA540, 8'd10},  // R10 stays array
    '{1'b1, 16'hC000, 16'h0060, 8'd7},
    '{1'b1, 16'h1234, 16'h0003, 8'd7},
    '{1'b1, 16'hC000, 16'h0090, 8'd11},
    '{1'b0, 16'hC005, 16'h1234, 8'd7},   // R7 value from address
    '{1'b1, 16'h0082, 16'h00C0, 8'd8},
    '{1'b0, 16'h0082, 16'h0080, 8'd8},   // R8 status while pending
    '{1'b1, 16'h0082, 16'hBEEF, 8'd8},
    '{1'b1, 16'h0000, 16'h0090, 8'd11},
    '{1'b0, 16'h0082, 16'hBEEF, 8'd8},   // R8 programmed word
    '{1'b1, 16'h0083, 16'h00C0, 8'd8},
    '{1'b1, 16'h0084, 16'h1111, 8'd8},   // R8 address mismatch
    '{1'b1, 16'h0000, 16'h0070, 8'd11},
    '{1'b0, 16'h0000, 16'h00A0, 8'd6},   // R6 mismatch flagged
    '{1'b1, 16'h0000, 16'h0090, 8'd11},
    '{1'b0, 16'h0084, 16'hFFFF, 8'd8},   // R8 no write done
    '{1'b1, 16'h8000, 16'h0060, 8'd7},
    '{1'b1, 16'h5555, 16'h0004, 8'd6},   // R6 bad confirm code
    '{1'b0, 16'h8000, 16'h00A0, 8'd6},   // R6 setup partition in status
    '{1'b0, 16'h0007, 16'h1234, 8'd7},   // R7 value unchanged
    '{1'b1, 16'h0000, 16'h0050, 8'd11},
    '{1'b1, 16'h0000, 16'h00FF, 8'd2},
    '{1'b0, 16'h0000, 16'hA500, 8'd2}    // R2
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] addr = '0, wrData = '0;
  logic [15:0] rdData;
  logic        rdValid;
  int          nChecks = 0, nFail = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ui #(.ERASE_CYCLES(ERASE_CYCLES)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [15:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check({tag, " rdValid (R13)"}, {15'd0, rdValid}, 16'd1);
    check(tag, rdData, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset outputs
    check("R1 rdValid at reset", {15'd0, rdValid}, 16'd0);
    check("R1 rdData at reset", rdData, 16'h0000);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWr) doWrite(VECS[i].addr, VECS[i].data);
      else doRead(VECS[i].addr, VECS[i].data, $sformatf("R%0d vec %0d", VECS[i].req, i));
    end

    // R13: idle cycle drops rdValid
    @(negedge clk);
    check("R13 rdValid idle", {15'd0, rdValid}, 16'd0);

    // R4/R5/R12: erase with reads in between, writes while busy
    doWrite(16'h4010, 16'h0020);
    doRead(16'h4010, 16'h0080, "R3 erase setup status");
    doRead(16'h0011, 16'hA511, "R4 other partition during pending");
    doRead(16'h4013, 16'h0080, "R4 still pending");
    doWrite(16'h4015, 16'h00D0);
    doRead(16'h4010, 16'h0000, "R5 busy bit clear");
    doWrite(16'h8000, 16'h0090);   // R12 ignored
    doWrite(16'h0000, 16'h0070);   // R12 ignored
    repeat (ERASE_CYCLES) @(negedge clk);
    doRead(16'h4010, 16'h0080, "R5 ready after erase");
    doRead(16'h8000, 16'h0080, "R12 partition 2 mode unchanged");
    doRead(16'h0001, 16'hA501, "R12 partition 0 mode unchanged");
    doWrite(16'h4000, 16'h00FF);
    doRead(16'h4010, 16'hFFFF, "R5 erased first word");
    doRead(16'h401F, 16'hFFFF, "R5 erased last word");
    doRead(16'h400F, 16'hA54F, "R5 block below kept");
    doRead(16'h4020, 16'hA560, "R5 block above kept");

    // R9: lock then attempt protection program
    doWrite(16'h0080, 16'h00C0);
    doWrite(16'h0080, 16'hFFFD);
    doWrite(16'h0081, 16'h00C0);
    doWrite(16'h0081, 16'h1357);
    doWrite(16'h0000, 16'h0070);
    doRead(16'h0000, 16'h0090, "R9 program error bit");
    doWrite(16'h0000, 16'h0090);
    doRead(16'h0080, 16'hFFFD, "R9 lock word");
    doRead(16'h0081, 16'hFFFF, "R9 protected word unchanged");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule